// File: doc/BRIEF.md
# Clock Output Gating Controller

This block decides, for each of six differential clock outputs and for one single-ended reference output, whether the output runs or is held quiet. It combines a power-good/power-down pin, six active-low output enable pins, six internal enable bits, a PLL lock flag, and two board straps. It produces one gate control per differential output, an output-enable and a run control for the reference output, a latched 7-bit bus address, and a latched spread-spectrum code.

The control logic runs on a free-running control clock. Each differential gate is handed into the clock domain of its own output. There it is resynchronized and updated only on the falling edge of that output clock, so a gated output never produces a shortened pulse. The PLL lock flag is resynchronized directly in each output domain, so a loss of lock shuts the outputs without waiting for the control domain. The reference output stays high-impedance after power-on until power-good is first seen high. The straps are captured at that same moment.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, every `dif_gate` bit, `ref_oe` and `ref_run` are 0. After reset all six internal enable bits are 1, so with power-good high, lock present and all pins asserted, every output runs without any write.
- R2: While the synchronized power-good level is low, all six `dif_gate` bits settle to 0, whatever the enable pins or enable bits hold.
- R3: While power-good is high and lock is present, `dif_gate[i]` settles to 1 exactly when enable bit i is 1 and `oe_pin_n[i]` is 0 (active low). Otherwise it settles to 0.
- R4: `ref_oe` is 0 (reference high-impedance) from reset until power-good is first seen high. From then until the next reset it is 1, and `ref_run` follows the synchronized power-good level, so a later low level drives the reference low instead of releasing it.
- R5: `addr_strap` is captured on the first power-good rise after reset. Value 0 gives `smb_addr` = 7'b1101000 (0x68) and value 1 gives 7'b1101010 (0x6A). Before the capture `smb_addr` reads 0x68. Later strap changes and later power-good pulses leave it unchanged.
- R6: `spread_strap` is captured on the same edge as the address strap and held until reset. `spread_code` is 2'b00 for no spread, 2'b01 for -0.25% and 2'b10 for -0.5%. A strap value of 2'b11 is taken as 2'b00. Before the capture the code reads 2'b00.
- R7: With `pll_lock` low, every `dif_gate` stays 0. When lock falls while outputs run, `dif_gate[i]` reaches 0 within three periods of `out_clk[i]`.
- R8: A `dif_gate[i]` bit changes only at a falling edge of `out_clk[i]`, so it is constant throughout every high phase of that clock.
- R9: A control-clock cycle with `en_wr` high loads `en_wdata` into the six enable bits. A 0 bit then keeps that output off even with its pin asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| pwrgd_pd_in | input | 1 | Power-good (high) / power-down (low) pin, asynchronous |
| oe_pin_n | input | 6 | Per-output enable pins, active low, asynchronous |
| en_wr | input | 1 | Load strobe for the enable bits |
| en_wdata | input | 6 | New enable-bit values |
| pll_lock | input | 1 | PLL lock flag, asynchronous |
| addr_strap | input | 1 | Address-select strap |
| spread_strap | input | 2 | Spread-select strap |
| out_clk | input | 6 | Clock of each differential output |
| dif_gate | output | 6 | 1 lets output i run, 0 holds both legs low |
| ref_oe | output | 1 | Reference output driver enable (0 = high-impedance) |
| ref_run | output | 1 | Reference runs when 1, driven low when 0 with ref_oe high |
| smb_addr | output | 7 | Latched 7-bit bus address |
| spread_code | output | 2 | Latched spread setting |

## Verification
The assertions check on every cycle of the relevant clock that the sticky power-good flag never clears, that the reference is never run while high-impedance, that the latched address and spread code never move once captured and never take an illegal value, that no gate is open while the per-domain lock copy is low, that the control-side request is empty without power-good, and that a gate never moves during a high phase of its clock. Only the bench scenarios can show the end-to-end mapping from pins, enable bits and lock to each gate through two clock crossings. The same holds for the enable-bit reset default, for each strap decoding across repeated resets, and for the wall-clock bound on shutdown after lock loss.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

  typedef enum logic [1:0] {
    SPREAD_OFF     = 2'b00,
    SPREAD_QUARTER = 2'b01,
    SPREAD_HALF    = 2'b10
  } spread_e;

  localparam int ADDR_W = 7;

  // Fixed upper bits of the bus address; the strap fills bit 1.
  function automatic logic [ADDR_W-1:0] bus_addr_of(input logic sel);
    return {5'b11010, sel, 1'b0};
  endfunction

  function automatic spread_e spread_of(input logic [1:0] strap);
    spread_e res;
    case (strap)
      2'b01:   res = SPREAD_QUARTER;
      2'b10:   res = SPREAD_HALF;
      default: res = SPREAD_OFF;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/cg_rst_sync.sv
module cg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  // Asserts at once, releases on the STAGES-th clock edge.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/cg_sync_bits.sv
module cg_sync_bits #(
  parameter int               WIDTH     = 1,
  parameter int               STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {STAGES{RESET_VAL}};
    else        stage_q <= stage_d;
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/cg_pgood_tracker.sv
module cg_pgood_tracker
  import clkgate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg_s,
  input  logic              addr_strap,
  input  logic [1:0]        spread_strap,
  output logic              ref_oe,
  output logic              ref_run,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        spread_code
);

  logic              seen_q, seen_d;
  logic              run_q, run_d;
  logic              capture;
  logic [ADDR_W-1:0] addr_q, addr_d;
  spread_e           spread_q, spread_d;

  always_comb begin
    capture  = pg_s && !seen_q;
    seen_d   = seen_q | capture;
    run_d    = pg_s;
    addr_d   = capture ? bus_addr_of(addr_strap) : addr_q;
    spread_d = capture ? spread_of(spread_strap) : spread_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q   <= 1'b0;
      run_q    <= 1'b0;
      addr_q   <= bus_addr_of(1'b0);
      spread_q <= SPREAD_OFF;
    end else begin
      seen_q   <= seen_d;
      run_q    <= run_d;
      addr_q   <= addr_d;
      spread_q <= spread_d;
    end
  end

  assign ref_oe      = seen_q;
  assign ref_run     = run_q;
  assign bus_addr    = addr_q;
  assign spread_code = spread_q;

  p_seen_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |=> seen_q);

  p_ref_run_needs_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> seen_q);

  p_addr_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |=> $stable(addr_q));

  p_addr_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q == 7'h68) || (addr_q == 7'h6A));

  p_spread_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |=> $stable(spread_q));

  p_spread_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    spread_q != 2'b11);

endmodule

// File: rtl/cg_out_gate.sv
module cg_out_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic out_clk,
  input  logic arst_n,
  input  logic want,
  input  logic pll_lock,
  output logic gate
);

  logic       o_rst_n;
  logic [1:0] raw_in;
  logic [1:0] sync_out;
  logic       want_s, lock_s;
  logic       gate_q, gate_d;
  logic       gate_at_rise_q;

  cg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (out_clk),
    .arst_n (arst_n),
    .srst_n (o_rst_n)
  );

  assign raw_in = {pll_lock, want};

  cg_sync_bits #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(2'b00)) u_sync (
    .clk   (out_clk),
    .rst_n (o_rst_n),
    .d     (raw_in),
    .q     (sync_out)
  );

  assign want_s = sync_out[0];
  assign lock_s = sync_out[1];

  always_comb begin
    gate_d = want_s & lock_s;
  end

  // Update on the falling edge: the gate moves only while the clock is low.
  always_ff @(negedge out_clk or negedge o_rst_n) begin
    if (!o_rst_n) gate_q <= 1'b0;
    else          gate_q <= gate_d;
  end

  assign gate = gate_q;

  // Check-only copy of the gate as seen at the rising edge.
  always_ff @(posedge out_clk or negedge o_rst_n) begin
    if (!o_rst_n) gate_at_rise_q <= 1'b0;
    else          gate_at_rise_q <= gate_q;
  end

  p_no_gate_without_lock_r7: assert property (@(posedge out_clk) disable iff (!o_rst_n)
    !lock_s |-> !gate_q);

  p_gate_steady_high_phase_r8: assert property (@(negedge out_clk) disable iff (!o_rst_n)
    gate_q == gate_at_rise_q);

endmodule

// File: rtl/clkout_gate_ctrl.sv
module clkout_gate_ctrl
  import clkgate_pkg::*;
#(
  parameter int N_OUT       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              ctl_clk,
  input  logic              rst_n,
  input  logic              pwrgd_pd_in,
  input  logic [N_OUT-1:0]  oe_pin_n,
  input  logic              en_wr,
  input  logic [N_OUT-1:0]  en_wdata,
  input  logic              pll_lock,
  input  logic              addr_strap,
  input  logic [1:0]        spread_strap,
  input  logic [N_OUT-1:0]  out_clk,
  output logic [N_OUT-1:0]  dif_gate,
  output logic              ref_oe,
  output logic              ref_run,
  output logic [ADDR_W-1:0] smb_addr,
  output logic [1:0]        spread_code
);

  localparam logic [N_OUT-1:0] ALL_ON = {N_OUT{1'b1}};

  logic             c_rst_n;
  logic             pg_s;
  logic [N_OUT-1:0] oe_s_n;
  logic [N_OUT-1:0] en_q, en_d;
  logic [N_OUT-1:0] want_q, want_d;

  cg_rst_sync #(.STAGES(SYNC_STAGES)) u_ctl_rst (
    .clk    (ctl_clk),
    .arst_n (rst_n),
    .srst_n (c_rst_n)
  );

  cg_sync_bits #(.WIDTH(1), .STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_pg_sync (
    .clk   (ctl_clk),
    .rst_n (c_rst_n),
    .d     (pwrgd_pd_in),
    .q     (pg_s)
  );

  cg_sync_bits #(.WIDTH(N_OUT), .STAGES(SYNC_STAGES), .RESET_VAL(ALL_ON)) u_oe_sync (
    .clk   (ctl_clk),
    .rst_n (c_rst_n),
    .d     (oe_pin_n),
    .q     (oe_s_n)
  );

  cg_pgood_tracker u_track (
    .clk          (ctl_clk),
    .rst_n        (c_rst_n),
    .pg_s         (pg_s),
    .addr_strap   (addr_strap),
    .spread_strap (spread_strap),
    .ref_oe       (ref_oe),
    .ref_run      (ref_run),
    .bus_addr     (smb_addr),
    .spread_code  (spread_code)
  );

  always_comb begin
    en_d   = en_wr ? en_wdata : en_q;
    want_d = {N_OUT{pg_s}} & en_q & ~oe_s_n;
  end

  always_ff @(posedge ctl_clk or negedge c_rst_n) begin
    if (!c_rst_n) begin
      en_q   <= ALL_ON;
      want_q <= '0;
    end else begin
      en_q   <= en_d;
      want_q <= want_d;
    end
  end

  for (genvar gi = 0; gi < N_OUT; gi++) begin : g_out
    cg_out_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .out_clk  (out_clk[gi]),
      .arst_n   (rst_n),
      .want     (want_q[gi]),
      .pll_lock (pll_lock),
      .gate     (dif_gate[gi])
    );
  end

  p_no_request_without_pg_r2: assert property (@(posedge ctl_clk) disable iff (!c_rst_n)
    !pg_s |=> (want_q == '0));

  p_request_needs_bit_r9: assert property (@(posedge ctl_clk) disable iff (!c_rst_n)
    (want_q & ~$past(en_q)) == '0);

endmodule

// File: tb/test_clkout_gate_ctrl.sv
`timescale 1ns/1ps
module test_clkout_gate_ctrl;

  logic       ctl_clk = 1'b0;
  logic       rst_n;
  logic       pwrgd_pd_in;
  logic [5:0] oe_pin_n;
  logic       en_wr;
  logic [5:0] en_wdata;
  logic       pll_lock;
  logic       addr_strap;
  logic [1:0] spread_strap;
  logic [5:0] out_clk = 6'b0;
  logic [5:0] dif_gate;
  logic       ref_oe;
  logic       ref_run;
  logic [6:0] smb_addr;
  logic [1:0] spread_code;

  int n_cmp = 0;
  int n_bad = 0;
  logic [5:0] model_en;

  clkout_gate_ctrl i_clkout_gate_ctrl (
    .ctl_clk, .rst_n, .pwrgd_pd_in, .oe_pin_n, .en_wr, .en_wdata, .pll_lock,
    .addr_strap, .spread_strap, .out_clk, .dif_gate, .ref_oe, .ref_run,
    .smb_addr, .spread_code
  );

  always #2.5 ctl_clk = ~ctl_clk;
  for (genvar g = 0; g < 6; g++) begin : g_oclk
    always #(3.5 + g * 1.0) out_clk[g] = ~out_clk[g];
  end

  function automatic logic [5:0] exp_gate(logic pg, logic lk, logic [5:0] en, logic [5:0] pins_n);
    return (pg && lk) ? (en & ~pins_n) : 6'b0;
  endfunction

  function automatic logic [6:0] exp_addr(logic s);
    return s ? 7'h6A : 7'h68;
  endfunction

  function automatic logic [1:0] exp_spread(logic [1:0] s);
    return (s == 2'b11) ? 2'b00 : s;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_ctl(int n);
    repeat (n) @(negedge ctl_clk);
  endtask

  task automatic do_reset(logic a, logic [1:0] s);
    rst_n = 1'b0; pwrgd_pd_in = 1'b0; pll_lock = 1'b0; oe_pin_n = 6'h3F;
    en_wr = 1'b0; en_wdata = 6'h0; addr_strap = a; spread_strap = s;
    model_en = 6'h3F;
    wait_ctl(6);
    rst_n = 1'b1;
    wait_ctl(10);
  endtask

  task automatic write_en(logic [5:0] v);
    @(negedge ctl_clk);
    en_wr = 1'b1; en_wdata = v;
    @(negedge ctl_clk);
    en_wr = 1'b0;
    model_en = v;
  endtask

  // R8: gate must not move during a high phase of out_clk[0] / out_clk[3]
  always @(posedge out_clk[0]) begin
    logic g0;
    #0.5 g0 = dif_gate[0];
    #2.5 if (rst_n) check("R8 gate0 high phase", {31'b0, dif_gate[0]}, {31'b0, g0});
  end
  always @(posedge out_clk[3]) begin
    logic g3;
    #0.5 g3 = dif_gate[3];
    #5.5 if (rst_n) check("R8 gate3 high phase", {31'b0, dif_gate[3]}, {31'b0, g3});
  end

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; pwrgd_pd_in = 1'b0; pll_lock = 1'b0; oe_pin_n = 6'h3F;
    en_wr = 1'b0; en_wdata = 6'h0; addr_strap = 1'b1; spread_strap = 2'b10;
    model_en = 6'h3F;
    wait_ctl(4);
    // R1 reset state
    check("R1 gates in reset", {26'b0, dif_gate}, 32'h0);
    check("R1 ref_oe in reset", {31'b0, ref_oe}, 32'h0);
    check("R1 ref_run in reset", {31'b0, ref_run}, 32'h0);
    rst_n = 1'b1;
    wait_ctl(20);
    // R4 high-impedance before first power-good; R5/R6 defaults
    check("R4 ref hi-z before pg", {31'b0, ref_oe}, 32'h0);
    check("R5 addr before capture", {25'b0, smb_addr}, 32'h68);
    check("R6 spread before capture", {30'b0, spread_code}, 32'h0);
    // R1 default enable bits: all run
    pll_lock = 1'b1; oe_pin_n = 6'h00; pwrgd_pd_in = 1'b1;
    wait_ctl(60);
    check("R1 default enables run all", {26'b0, dif_gate}, 32'h3F);
    check("R4 ref driven after pg", {31'b0, ref_oe}, 32'h1);
    check("R4 ref runs with pg", {31'b0, ref_run}, 32'h1);
    check("R5 addr strap 1", {25'b0, smb_addr}, {25'b0, exp_addr(1'b1)});
    check("R6 spread strap 10", {30'b0, spread_code}, {30'b0, exp_spread(2'b10)});
    // R5/R6 later strap changes and pg pulses ignored; R2/R4 pg low
    addr_strap = 1'b0; spread_strap = 2'b01;
    pwrgd_pd_in = 1'b0;
    wait_ctl(60);
    check("R2 pg low gates off", {26'b0, dif_gate}, 32'h0);
    check("R4 ref driven low after pg", {30'b0, ref_oe, ref_run}, 32'h2);
    pwrgd_pd_in = 1'b1;
    wait_ctl(60);
    check("R5 addr held", {25'b0, smb_addr}, 32'h6A);
    check("R6 spread held", {30'b0, spread_code}, 32'h2);
    // R9 enable bits block outputs despite pins
    write_en(6'b101001);
    wait_ctl(60);
    check("R9 enable bits mask", {26'b0, dif_gate}, 32'h29);
    write_en(6'h3F);
    wait_ctl(60);
    // R7 lock loss timing
    #0.3;
    pll_lock = 1'b0;
    #20;
    check("R7 gate0 off within 3 periods", {31'b0, dif_gate[0]}, 32'h0);
    #40;
    check("R7 all gates off after lock loss", {26'b0, dif_gate}, 32'h0);
    pll_lock = 1'b1;
    wait_ctl(60);
    check("R7 relock resumes", {26'b0, dif_gate}, 32'h3F);
    // R3 / R2 / R7 / R9 random mix
    for (int it = 0; it < 40; it++) begin
      logic pg, lk;
      pg = ($urandom % 4) != 0;
      lk = ($urandom % 5) != 0;
      if (($urandom % 3) == 0) write_en(6'($urandom));
      pwrgd_pd_in = pg; pll_lock = lk; oe_pin_n = 6'($urandom);
      wait_ctl(60);
      check("R3 random gate map", {26'b0, dif_gate},
            {26'b0, exp_gate(pg, lk, model_en, oe_pin_n)});
      check("R4 random ref", {30'b0, ref_oe, ref_run}, {30'b0, 1'b1, pg});
    end
    // R6 / R5 other strap values across resets
    for (int k = 0; k < 3; k++) begin
      logic [1:0] sv;
      sv = (k == 0) ? 2'b11 : ((k == 1) ? 2'b01 : 2'b00);
      do_reset(1'b0, sv);
      check("R4 hi-z after new reset", {31'b0, ref_oe}, 32'h0);
      pwrgd_pd_in = 1'b1; pll_lock = 1'b1; oe_pin_n = 6'h15;
      wait_ctl(60);
      check("R5 addr strap 0", {25'b0, smb_addr}, {25'b0, exp_addr(1'b0)});
      check("R6 spread decode", {30'b0, spread_code}, {30'b0, exp_spread(sv)});
      check("R1 enables back to all ones", {26'b0, dif_gate}, 32'h2A);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule